// File: doc/BRIEF.md
# Asynchronous Backplane Bus Slave

This block is the responding end of a parallel backplane bus whose cycles have no fixed length. Each transfer completes through a four-edge exchange: the master asserts its strobes, the slave answers with an acknowledge, the master withdraws, and then the slave withdraws. The slave watches the address strobe, the address-modifier code and the address lines. It decides whether the cycle falls inside its own 64-byte window. It then completes exactly one single-beat read or write against a local file of sixteen 32-bit registers. Narrow transfers use big-endian byte lanes. An addressed transfer that the slave cannot carry out is answered with a bus-error strobe instead of an acknowledge.

Every bus input passes through a two-flop synchronizer. The state machine uses the strobes only as edges after synchronization. The machine has five states. IDLE waits for a fresh address-strobe assertion. HUNT is the addressed state and waits for the data strobe. SETTLE is one cycle in which the write is performed, or in which the read data is already on the lines. RESPOND holds the acknowledge or the bus error until the data strobe is removed. PARK waits for the address strobe to be negated and also absorbs cycles aimed elsewhere. The transitions are:
- IDLE to HUNT when the cycle hits the window.
- IDLE to PARK when it misses.
- HUNT to SETTLE when the data strobe is asserted.
- HUNT to IDLE when the address strobe is withdrawn early.
- SETTLE to RESPOND unconditionally.
- RESPOND to PARK when the data strobe is released.
- PARK to IDLE when the address strobe is released.

On the local side, every accepted bus write shows up as a one-cycle strobe carrying the register index, the byte enables and the merged word. A separate local read port reads any register at any time.

Top module: `abus_slave`

## Requirements
- R1: After reset, `dtack_n` and `berr_n` are high, `d_oe` is low and all sixteen registers read zero on the local read port.
- R2: A cycle starts only on a high-to-low transition of the synchronized `as_n`. Asserting `ds_n` again while `as_n` stays low after a completed cycle produces no acknowledge, no bus error and no write.
- R3: The window is decoded by the modifier code. Code 0x29 compares `addr[15:6]`, code 0x39 compares `addr[23:6]` and code 0x09 compares `addr[31:6]`, each against the same bits of `WIN_BASE`. Any other code, or any miss, gets no response at all.
- R4: For a write, the data is taken while `ds_n` is low, and `dtack_n` is asserted afterwards. `dtack_n` then stays low for as long as `ds_n` stays low.
- R5: For a read, `d_oe` is high and `d_out` is valid no later than the cycle in which `dtack_n` falls. After `ds_n` is released, `d_oe` goes low and `dtack_n` goes high.
- R6: `xsize` selects the width: 0 is a byte on `d[7:0]`, 1 is a halfword on `d[15:0]` and 2 is a full word. Lanes are big-endian: byte offset k (`addr[1:0]`) is register bits [31-8k:24-8k], and halfword offset 0 is bits [31:16] while offset 2 is bits [15:0]. Unused upper read bits are zero.
- R7: An addressed cycle with `xsize` 3, a halfword with `addr[0]` set, or a word with `addr[1:0]` not zero is answered on `berr_n` instead of `dtack_n`. The same release rule applies, no register changes and `d_oe` stays low.
- R8: Each accepted write pulses `loc_we` for exactly one cycle. During that pulse it presents `loc_widx`, `loc_wbe` (bit 3 is bits [31:24]) and the merged `loc_wdata`.
- R9: `loc_rdata` always returns the register selected by `loc_ridx`, including every write already acknowledged.
- R10: The register index is `addr[5:2]`. At most one of `dtack_n` and `berr_n` is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| write_n | input | 1 | Low for write, high for read |
| am | input | 6 | Address-modifier code |
| addr | input | 32 | Byte address |
| xsize | input | 2 | Transfer width code |
| d_in | input | 32 | Data lines as seen by the slave |
| d_out | output | 32 | Read data driven to the lines |
| d_oe | output | 1 | Output enable for d_out (tri-state control) |
| dtack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| loc_we | output | 1 | Local write strobe |
| loc_widx | output | 4 | Index of the written register |
| loc_wbe | output | 4 | Byte enables of the write |
| loc_wdata | output | 32 | Merged write word |
| loc_ridx | input | 4 | Local read index |
| loc_rdata | output | 32 | Local read data |

## Verification
The assertions assume that the master obeys the handshake. It sets the modifier, address, width, direction and write data before its strobes. It holds them until acknowledge has been withdrawn. It never asserts `ds_n` without `as_n`. The stimulus tasks keep to this. They set every bus field one clock before `as_n` falls and assert `ds_n` two clocks later. They release `ds_n` only after a response or a timeout, and they release `as_n` only after both response lines are high again. Within those rules the modifier, window hit, width, alignment and direction are drawn at random. Directed sequences cover a repeated data strobe under a held address strobe and the exact lane positions.

// File: rtl/abus_pkg.sv
package abus_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int AM_W   = 6;
    localparam int NREGS  = 16;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int BE_W   = DATA_W / 8;
    localparam int OFS_W  = IDX_W + 2;

    localparam logic [AM_W-1:0] AM_SHORT = 6'h29;
    localparam logic [AM_W-1:0] AM_MID   = 6'h39;
    localparam logic [AM_W-1:0] AM_LONG  = 6'h09;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsize_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SETTLE,
        ST_RESPOND,
        ST_PARK
    } slv_state_e;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/abus_decode.sv
module abus_decode
    import abus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1234_5640
) (
    input  logic [AM_W-1:0]   am,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        xsize,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] reg_word,
    output logic              hit,
    output logic              bad_xfer,
    output logic [IDX_W-1:0]  idx,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wword,
    output logic [DATA_W-1:0] rbus
);
    logic [1:0] ofs;
    assign ofs = addr[1:0];
    assign idx = addr[OFS_W-1:2];

    always_comb begin
        unique case (am)
            AM_SHORT: hit = (addr[15:OFS_W] == WIN_BASE[15:OFS_W]);
            AM_MID:   hit = (addr[23:OFS_W] == WIN_BASE[23:OFS_W]);
            AM_LONG:  hit = (addr[31:OFS_W] == WIN_BASE[31:OFS_W]);
            default:  hit = 1'b0;
        endcase
    end

    always_comb begin
        bad_xfer = 1'b0;
        be       = '0;
        wword    = bus_wdata;
        rbus     = '0;
        unique case (xsize_e'(xsize))
            SZ_BYTE: begin
                be    = 4'b1000 >> ofs;
                wword = {4{bus_wdata[7:0]}};
                unique case (ofs)
                    2'd0: rbus[7:0] = reg_word[31:24];
                    2'd1: rbus[7:0] = reg_word[23:16];
                    2'd2: rbus[7:0] = reg_word[15:8];
                    2'd3: rbus[7:0] = reg_word[7:0];
                    default: rbus[7:0] = '0;
                endcase
            end
            SZ_HALF: begin
                bad_xfer   = ofs[0];
                be         = ofs[1] ? 4'b0011 : 4'b1100;
                wword      = {2{bus_wdata[15:0]}};
                rbus[15:0] = ofs[1] ? reg_word[15:0] : reg_word[31:16];
            end
            SZ_WORD: begin
                bad_xfer = (ofs != 2'd0);
                be       = 4'b1111;
                rbus     = reg_word;
            end
            default: bad_xfer = 1'b1;
        endcase
    end
endmodule

// File: rtl/abus_regfile.sv
module abus_regfile
    import abus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BE_W-1:0]   wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < BE_W; b++)
                if (wbe[b]) mem_q[widx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign rdata_a = mem_q[ridx_a];
    assign rdata_b = mem_q[ridx_b];
endmodule

// File: rtl/abus_slave.sv
module abus_slave
    import abus_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h1234_5640,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        as_n,
    input  logic        ds_n,
    input  logic        write_n,
    input  logic [5:0]  am,
    input  logic [31:0] addr,
    input  logic [1:0]  xsize,
    input  logic [31:0] d_in,
    output logic [31:0] d_out,
    output logic        d_oe,
    output logic        dtack_n,
    output logic        berr_n,
    output logic        loc_we,
    output logic [3:0]  loc_widx,
    output logic [3:0]  loc_wbe,
    output logic [31:0] loc_wdata,
    input  logic [3:0]  loc_ridx,
    output logic [31:0] loc_rdata
);
    localparam int BUS_W = 3 + AM_W + ADDR_W + 2 + DATA_W;
    localparam logic [BUS_W-1:0] BUS_RST = {3'b111, {(BUS_W-3){1'b0}}};

    logic              as_s, ds_s, wrn_s;
    logic [AM_W-1:0]   am_s;
    logic [ADDR_W-1:0] addr_s;
    logic [1:0]        xsize_s;
    logic [DATA_W-1:0] din_s;

    abus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({as_n, ds_n, write_n, am, addr, xsize, d_in}),
        .dout ({as_s, ds_s, wrn_s, am_s, addr_s, xsize_s, din_s})
    );

    logic              dec_hit, dec_bad;
    logic [IDX_W-1:0]  dec_idx;
    logic [BE_W-1:0]   dec_be;
    logic [DATA_W-1:0] dec_wword, dec_rbus, bus_word;

    abus_decode #(.WIN_BASE(WIN_BASE)) u_dec (
        .am       (am_s),
        .addr     (addr_s),
        .xsize    (xsize_s),
        .bus_wdata(din_s),
        .reg_word (bus_word),
        .hit      (dec_hit),
        .bad_xfer (dec_bad),
        .idx      (dec_idx),
        .be       (dec_be),
        .wword    (dec_wword),
        .rbus     (dec_rbus)
    );

    slv_state_e state_q, state_d;
    logic as_prev_q, cyc_err_q, cyc_rd_q;
    logic [DATA_W-1:0] rd_q;
    logic as_start, wr_fire;

    assign as_start = as_prev_q && !as_s;
    assign wr_fire  = (state_q == ST_HUNT) && !ds_s && !as_s && !cyc_rd_q && !cyc_err_q;

    abus_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_fire),
        .widx   (dec_idx),
        .wbe    (dec_be),
        .wdata  (dec_wword),
        .ridx_a (dec_idx),
        .rdata_a(bus_word),
        .ridx_b (loc_ridx),
        .rdata_b(loc_rdata)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (as_start) state_d = dec_hit ? ST_HUNT : ST_PARK;
            ST_HUNT:    if (as_s) state_d = ST_IDLE;
                        else if (!ds_s) state_d = ST_SETTLE;
            ST_SETTLE:  state_d = ST_RESPOND;
            ST_RESPOND: if (ds_s) state_d = ST_PARK;
            ST_PARK:    if (as_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            as_prev_q <= 1'b1;
            cyc_err_q <= 1'b0;
            cyc_rd_q  <= 1'b0;
            rd_q      <= '0;
        end else begin
            state_q   <= state_d;
            as_prev_q <= as_s;
            if (state_q == ST_IDLE && as_start) begin
                cyc_err_q <= dec_bad;
                cyc_rd_q  <= wrn_s;
            end
            if (state_q == ST_HUNT && !ds_s) rd_q <= dec_rbus;
        end
    end

    always_comb begin
        dtack_n   = !(state_q == ST_RESPOND && !cyc_err_q);
        berr_n    = !(state_q == ST_RESPOND && cyc_err_q);
        d_oe      = (state_q == ST_SETTLE || state_q == ST_RESPOND) && cyc_rd_q && !cyc_err_q;
        d_out     = rd_q;
        loc_we    = wr_fire;
        loc_widx  = dec_idx;
        loc_wbe   = dec_be;
        loc_wdata = dec_wword;
    end

    assert_resp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !berr_n));
    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !ds_s) |=> !dtack_n);
    assert_berr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_n && !ds_s) |=> !berr_n);
    assert_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtack_n) && cyc_rd_q) |-> d_oe);
    assert_oe_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |-> !d_oe);
    assert_write_before_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |-> (dtack_n && berr_n));
    assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |=> !loc_we);
endmodule

// File: tb/sim_abus_slave.sv
`timescale 1ns/1ps
module sim_abus_slave;
    localparam logic [31:0] BASE = 32'h1234_5640;

    logic clk = 1'b0, rst_n = 1'b0;
    logic as_n = 1'b1, ds_n = 1'b1, write_n = 1'b1;
    logic [5:0] am = '0;
    logic [31:0] addr = '0, d_in = '0;
    logic [1:0] xsize = '0;
    logic [3:0] loc_ridx = '0;
    logic [31:0] d_out, loc_wdata, loc_rdata;
    logic d_oe, dtack_n, berr_n, loc_we;
    logic [3:0] loc_widx, loc_wbe;

    int n_chk = 0, n_fail = 0, we_seen = 0, we_exp = 0;
    logic [3:0] last_widx, last_wbe;
    logic [31:0] last_wdata;
    logic [31:0] model [16];
    bit finished = 0;

    always #2.5 clk = ~clk;

    abus_slave #(.WIN_BASE(BASE)) u0 (.*);

    always @(negedge clk) if (rst_n && loc_we) begin
        we_seen++; last_widx = loc_widx; last_wbe = loc_wbe; last_wdata = loc_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit f_hit(input [5:0] m, input [31:0] a);
        case (m)
            6'h29: return a[15:6] == BASE[15:6];
            6'h39: return a[23:6] == BASE[23:6];
            6'h09: return a[31:6] == BASE[31:6];
            default: return 0;
        endcase
    endfunction

    function automatic bit f_bad(input [1:0] sz, input [31:0] a);
        return sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0);
    endfunction

    function automatic [31:0] f_rbus(input [31:0] w, input [1:0] sz, input [1:0] o);
        if (sz == 0) return {24'h0, w[31 - 8*o -: 8]};
        if (sz == 1) return {16'h0, o[1] ? w[15:0] : w[31:16]};
        return w;
    endfunction

    task automatic f_write(input [31:0] a, input [1:0] sz, input [31:0] d);
        logic [3:0] i;
        i = a[5:2];
        if (sz == 0) model[i][31 - 8*a[1:0] -: 8] = d[7:0];
        else if (sz == 1) begin
            if (a[1]) model[i][15:0] = d[15:0]; else model[i][31:16] = d[15:0];
        end else model[i] = d;
    endtask

    task automatic bus_op(input [5:0] m, input [31:0] a, input [1:0] sz, input bit wr,
                          input [31:0] wd, output bit ack, output bit err,
                          output [31:0] rd, output bit oe_ok, output bit hold_ok,
                          output bit rel_ok);
        @(negedge clk);
        am = m; addr = a; xsize = sz; write_n = !wr; d_in = wd;
        @(negedge clk); as_n = 1'b0;
        repeat (2) @(negedge clk);
        ds_n = 1'b0;
        ack = 0; err = 0; rd = '0; oe_ok = 1; hold_ok = 1; rel_ok = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!dtack_n || !berr_n) begin
                ack = !dtack_n; err = !berr_n; rd = d_out;
                oe_ok = (d_oe == (!wr && ack));
                break;
            end
        end
        if (ack || err) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if ((!dtack_n) != ack || (!berr_n) != err) hold_ok = 0;
            end
        end
        ds_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (dtack_n && berr_n && !d_oe) begin rel_ok = 1; break; end
        end
        as_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic loc_check(input [3:0] i, input string req);
        loc_ridx = i;
        @(negedge clk);
        chk(loc_rdata == model[i], req, loc_rdata, model[i]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit ack, err, oe_ok, hold_ok, rel_ok, hit, bad;
        logic [31:0] rd, a, w, e;
        logic [5:0] m;
        logic [1:0] sz;
        bit wr;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        chk(dtack_n && berr_n && !d_oe, "R1 reset outputs", {dtack_n, berr_n, d_oe}, 3'b110);
        loc_ridx = 4'd7; @(negedge clk);
        chk(loc_rdata == 0, "R1 reset regs", loc_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4/R8/R10: word write to index 3 through the 32-bit window
        bus_op(6'h09, BASE | 32'h0C, 2'd2, 1, 32'hDEADBEEF, ack, err, rd, oe_ok, hold_ok, rel_ok);
        f_write(BASE | 32'h0C, 2'd2, 32'hDEADBEEF); we_exp++;
        chk(ack && !err, "R4 write ack", {ack, err}, 2'b10);
        chk(hold_ok && rel_ok, "R4 hold/release", {hold_ok, rel_ok}, 2'b11);
        chk(last_widx == 4'd3 && last_wbe == 4'hF, "R10 index/be", {last_widx, last_wbe}, 8'h3F);
        loc_check(4'd3, "R9 local read");

        // R6: byte lanes big-endian
        for (int k = 0; k < 4; k++) begin
            bus_op(6'h39, (BASE & 32'h00FF_FFFF) | 32'h0C | k, 2'd0, 0, 0, ack, err, rd, oe_ok, hold_ok, rel_ok);
            e = f_rbus(model[3], 2'd0, k[1:0]);
            chk(ack && rd == e, "R6 byte lane read", rd, e);
            chk(oe_ok && rel_ok, "R5 read drive/release", {oe_ok, rel_ok}, 2'b11);
        end
        bus_op(6'h29, (BASE & 32'hFFFF) | 32'h0E, 2'd1, 0, 0, ack, err, rd, oe_ok, hold_ok, rel_ok);
        chk(rd == 32'h0000BEEF, "R6 half lane read", rd, 32'h0000BEEF);

        // R8: byte write at offset 1 of index 5
        bus_op(6'h09, BASE | 32'h15, 2'd0, 1, 32'h0000_00A5, ack, err, rd, oe_ok, hold_ok, rel_ok);
        f_write(BASE | 32'h15, 2'd0, 32'hA5); we_exp++;
        chk(last_wbe == 4'b0100 && last_wdata[23:16] == 8'hA5, "R8 write strobe fields",
            {last_wbe, last_wdata[23:16]}, {4'b0100, 8'hA5});
        loc_check(4'd5, "R8 merged write");

        // R7: misaligned word write -> bus error, no change
        bus_op(6'h09, BASE | 32'h16, 2'd2, 1, 32'hFFFF_FFFF, ack, err, rd, oe_ok, hold_ok, rel_ok);
        chk(err && !ack && hold_ok && rel_ok, "R7 bus error", {ack, err, hold_ok, rel_ok}, 4'b0111);
        loc_check(4'd5, "R7 no write on error");

        // R2: second data strobe under a held address strobe is ignored
        @(negedge clk);
        am = 6'h09; addr = BASE | 32'h20; xsize = 2'd2; write_n = 1'b0; d_in = 32'h1111_2222;
        @(negedge clk); as_n = 1'b0;
        repeat (2) @(negedge clk); ds_n = 1'b0;
        repeat (8) @(negedge clk); ds_n = 1'b1;
        repeat (6) @(negedge clk);
        f_write(BASE | 32'h20, 2'd2, 32'h1111_2222); we_exp++;
        d_in = 32'h3333_4444; ds_n = 1'b0; ack = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!dtack_n || !berr_n || loc_we) ack = 1;
        end
        chk(!ack, "R2 no response under held strobe", ack, 0);
        ds_n = 1'b1; as_n = 1'b1; repeat (4) @(negedge clk);
        loc_check(4'd8, "R2 register unchanged");

        // random traffic
        for (int it = 0; it < 300; it++) begin
            case ($urandom % 4)
                0: m = 6'h29;
                1: m = 6'h39;
                2: m = 6'h09;
                default: m = 6'h3D;
            endcase
            a = {$urandom} & 32'hFFFF_FFC0;
            if (m == 6'h29) a = {a[31:16], BASE[15:6], 6'h0};
            else if (m == 6'h39) a = {a[31:24], BASE[23:6], 6'h0};
            else a = BASE;
            if ($urandom % 8 == 0) a = a ^ (32'h40 << ($urandom % 20));
            a = a | ($urandom % 64);
            sz = ($urandom % 8 == 7) ? 2'd3 : 2'($urandom % 3);
            wr = $urandom % 2;
            w = $urandom;
            hit = f_hit(m, a); bad = f_bad(sz, a);
            bus_op(m, a, sz, wr, w, ack, err, rd, oe_ok, hold_ok, rel_ok);
            if (!hit) chk(!ack && !err, "R3 miss no response", {ack, err}, 0);
            else if (bad) chk(err && !ack && hold_ok && rel_ok, "R7 random bus error",
                              {ack, err, hold_ok, rel_ok}, 4'b0111);
            else begin
                chk(ack && !err && hold_ok, "R4 random ack", {ack, err, hold_ok}, 3'b101);
                chk(rel_ok && oe_ok, "R5 random drive/release", {rel_ok, oe_ok}, 2'b11);
                if (wr) begin f_write(a, sz, w); we_exp++; end
                else begin
                    e = f_rbus(model[a[5:2]], sz, a[1:0]);
                    chk(rd == e, "R6 random read", rd, e);
                end
            end
            loc_check(4'($urandom % 16), "R9 random local read");
        end

        chk(we_seen == we_exp, "R8 write strobe count", we_seen, we_exp);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule